// File: doc/BRIEF.md
# I2C Configuration Register Target with Write Lock

This block is an I2C target that keeps a small bank of eight-bit configuration registers for the surrounding chip. A bus master reaches the bank through an internal pointer: a write transaction first loads the pointer and then stores any number of data bytes into consecutive registers, and a read transaction streams bytes out from wherever the pointer currently stands, with no pointer phase of its own. Every register's value is presented in parallel on one flat output bus, so the rest of the chip sees configuration changes as soon as a byte has been accepted.

The SCL and SDA lines are open drain: the block samples both through a two-flop synchronizer on its own faster clock and pulls SDA low through an enable output. The seven-bit device address comes from a strap input. Slot 3 of the seven-slot map is reserved and the top three slots are protected: while the power-ok input is high, bytes aimed at them are acknowledged and then discarded.

Top module: `cfg_i2c_target`

## Requirements
- R1: After an active-low reset every register reads 0x00 on `regs_o`, the pointer is 0x00 and `sda_oe` is low.
- R2: SDA falling while SCL is high starts a transaction; SDA rising while SCL is high ends it, and the block is then idle with SDA released. The block only starts pulling SDA low while SCL is low.
- R3: The first byte after a start is sent MSB first as seven address bits followed by a direction bit (0 write, 1 read). The block pulls SDA low in the ninth clock only when the seven bits equal `dev_addr`; otherwise it keeps SDA released for the rest of the transaction.
- R4: In a write, the byte after the control byte loads the pointer, and each following data byte (MSB first) is stored at the pointer, after which the pointer advances. The block acknowledges the pointer byte and every data byte.
- R5: The pointer advances by one only while it is below 6; at 6 it stays, so further bytes overwrite register 6, and above 6 it keeps its value and writes there change nothing.
- R6: Slot 3 is reserved: a write to it is acknowledged and changes no register, and it always reads 0x00.
- R7: Registers 4, 5 and 6 change only while `pwr_ok` is low; while it is high, bytes aimed at them are acknowledged and leave every register unchanged. Registers 0 to 2 are writable at either level of `pwr_ok`.
- R8: A read returns the register at the current pointer and advances the pointer after each byte; the block sends another byte while the master acknowledges and releases SDA and goes idle after a master NACK. Pointer values 3 and above 6 read as 0x00.
- R9: Register i appears on `regs_o[8*i+7:8*i]` for i from 0 to 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than SCL |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | High pulls SDA low |
| dev_addr | input | 7 | Strapped device address |
| pwr_ok | input | 1 | High locks registers 4 to 6 |
| regs_o | output | 56 | All registers side by side, register 0 in the low byte |

## Verification
The assertions watch on every cycle that SDA is only pulled low while SCL is low, that a stop leaves the block idle with SDA released, that an acknowledge of a control byte only follows an address match, and that the locked registers hold still while power-ok is high. Whether each byte lands in the right register, how the pointer saturates, what reads of the reserved slot and of out-of-range pointers return, and how a master NACK ends a read can only be shown by the bench's transactions, which compare acknowledges, read data and the parallel register bus against a model.

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target #(
  parameter int NREG      = 7,
  parameter int RSVD      = 3,
  parameter int LOCK_BASE = 4,
  parameter int DW        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [6:0]        dev_addr,
  input  logic              pwr_ok,
  output logic [NREG*DW-1:0] regs_o
);

  localparam int AW   = $clog2(NREG);
  localparam int CW   = $clog2(DW + 2);
  localparam logic [DW-1:0] LAST = DW'(NREG - 1);

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_REG, S_WR, S_RD, S_IGN} st_t;

  logic [2:0]    scl_sy, sda_sy;
  logic [DW-1:0] mem [NREG];
  logic [DW-1:0] ptr, shreg, txb, rd_val;
  logic [CW-1:0] bitcnt;
  logic          mack, rd_first;
  st_t           st;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
    end

  wire scl    = scl_sy[1];
  wire sda    = sda_sy[1];
  wire start  = scl & scl_sy[2] & sda_sy[2] & ~sda;
  wire stop   = scl & scl_sy[2] & ~sda_sy[2] & sda;
  wire rise   = scl & ~scl_sy[2];
  wire fall   = ~scl & scl_sy[2];

  wire              ptr_ok  = ptr < DW'(NREG);
  wire              ptr_rsv = ptr == DW'(RSVD);
  wire              ptr_lck = ptr >= DW'(LOCK_BASE);
  wire              wr_ok   = ptr_ok & ~ptr_rsv & ~(ptr_lck & pwr_ok);
  wire [DW-1:0]     ptr_inc = (ptr < LAST) ? ptr + 1'b1 : ptr;

  always_comb begin
    rd_val = '0;
    if (ptr_ok && !ptr_rsv) rd_val = mem[ptr[AW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bitcnt   <= '0;
      sda_oe   <= 1'b0;
      ptr      <= '0;
      shreg    <= '0;
      txb      <= '0;
      mack     <= 1'b1;
      rd_first <= 1'b0;
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (start) begin
      st     <= S_CTRL;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop) begin
      st     <= S_IDLE;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (st != S_IDLE) begin
      if (rise) begin
        if (bitcnt < CW'(DW)) begin
          shreg  <= {shreg[DW-2:0], sda};
          bitcnt <= bitcnt + 1'b1;
        end else if (bitcnt == CW'(DW)) begin
          mack   <= sda;
          bitcnt <= CW'(DW + 1);
        end
      end else if (fall) begin
        if (bitcnt == CW'(DW)) begin
          case (st)
            S_CTRL:
              if (shreg[DW-1:1] == dev_addr) begin
                sda_oe   <= 1'b1;
                rd_first <= 1'b1;
                st       <= shreg[0] ? S_RD : S_REG;
              end else begin
                st <= S_IGN;
              end
            S_REG: begin
              ptr    <= shreg;
              sda_oe <= 1'b1;
              st     <= S_WR;
            end
            S_WR: begin
              if (wr_ok) mem[ptr[AW-1:0]] <= shreg;
              ptr    <= ptr_inc;
              sda_oe <= 1'b1;
            end
            S_RD: begin
              sda_oe <= 1'b0;
              ptr    <= ptr_inc;
            end
            default: ;
          endcase
        end else if (bitcnt == CW'(DW + 1)) begin
          bitcnt <= '0;
          if (st == S_RD) begin
            if (rd_first || !mack) begin
              txb      <= rd_val << 1;
              sda_oe   <= ~rd_val[DW-1];
              rd_first <= 1'b0;
            end else begin
              st     <= S_IDLE;
              sda_oe <= 1'b0;
            end
          end else begin
            sda_oe <= 1'b0;
          end
        end else if (st == S_RD && bitcnt != '0) begin
          sda_oe <= ~txb[DW-1];
          txb    <= txb << 1;
        end
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    if (g == RSVD) begin : g_rsv
      assign regs_o[g*DW +: DW] = '0;
    end else begin : g_reg
      assign regs_o[g*DW +: DW] = mem[g];
    end
  end

  a_r2_drive_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl);

  a_r2_stop_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (st == S_IDLE && !sda_oe));

  a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);

  a_r3_ack_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && $past(st) == S_CTRL) |-> ($past(shreg[DW-1:1]) == $past(dev_addr)));

  a_r7_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_ok |=> $stable(regs_o[NREG*DW-1:LOCK_BASE*DW]));

endmodule

// File: tb/test_cfg_i2c_target.sv
module test_cfg_i2c_target;

  localparam logic [6:0] DEV = 7'h56;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        pwr_ok = 1'b0;
  logic        sda_oe;
  logic [55:0] regs_o;
  wire         sda_bus = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [7];
  logic [7:0] mptr;

  always #4 clk = ~clk;

  cfg_i2c_target i_cfg_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .dev_addr(DEV), .pwr_ok(pwr_ok), .regs_o(regs_o)
  );

  function automatic logic [7:0] exp_rd(input logic [7:0] p);
    return (p < 8'd7 && p != 8'd3) ? mdl[p[2:0]] : 8'h00;
  endfunction

  function automatic logic [7:0] nxt(input logic [7:0] p);
    return (p < 8'd6) ? p + 8'd1 : p;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; scl_m = 1'b1; tick(8);
    sda_m = 1'b0; tick(8);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; tick(4);
    scl_m = 1'b1; tick(8);
    sda_m = 1'b1; tick(8);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(4);
      scl_m = 1'b1; tick(8);
      scl_m = 1'b0; tick(4);
    end
    sda_m = 1'b1; tick(4);
    scl_m = 1'b1; tick(4);
    ack = !sda_bus; tick(4);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(4);
      scl_m = 1'b1; tick(4);
      b[i] = sda_bus; tick(4);
      scl_m = 1'b0; tick(4);
    end
    sda_m = nack; tick(4);
    scl_m = 1'b1; tick(8);
    scl_m = 1'b0; tick(4);
    sda_m = 1'b1;
  endtask

  task automatic cmp_all(input string tag);
    for (int r = 0; r < 7; r++)
      chk(tag, {24'h0, regs_o[r*8 +: 8]}, {24'h0, (r == 3) ? 8'h00 : mdl[r]});
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] p, input int n, input string tag);
    logic ack;
    logic [7:0] d;
    i2c_start();
    send_byte({a, 1'b0}, ack);
    chk("R3", {31'h0, ack}, {31'h0, a == DEV});
    if (a == DEV) begin
      send_byte(p, ack);
      chk("R4", {31'h0, ack}, 32'h1);
      mptr = p;
      for (int k = 0; k < n; k++) begin
        d = 8'($urandom);
        send_byte(d, ack);
        chk(tag, {31'h0, ack}, 32'h1);
        if (mptr < 8'd7 && mptr != 8'd3 && !(mptr >= 8'd4 && pwr_ok)) mdl[mptr[2:0]] = d;
        mptr = nxt(mptr);
      end
    end else begin
      send_byte(p, ack);
      chk("R3", {31'h0, ack}, 32'h0);
    end
    i2c_stop();
    chk("R2", {31'h0, sda_oe}, 32'h0);
    cmp_all(tag);
  endtask

  task automatic do_read(input int n, input string tag);
    logic ack;
    logic [7:0] b;
    i2c_start();
    send_byte({DEV, 1'b1}, ack);
    chk("R3", {31'h0, ack}, 32'h1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k == n - 1, b);
      chk(tag, {24'h0, b}, {24'h0, exp_rd(mptr)});
      mptr = nxt(mptr);
    end
    tick(2);
    chk("R8", {31'h0, sda_oe}, 32'h0);
    i2c_stop();
    chk("R2", {31'h0, sda_oe}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int r = 0; r < 7; r++) mdl[r] = 8'h00;
    mptr = 8'h00;
    tick(5);
    chk("R1", {31'h0, sda_oe}, 32'h0);
    chk("R1", regs_o[31:0], 32'h0);
    chk("R1", {8'h0, regs_o[55:32]}, 32'h0);
    rst_n = 1'b1;
    tick(5);
    do_read(1, "R1");

    do_write(DEV, 8'h00, 3, "R4");
    do_read(2, "R8");
    do_write(DEV, 8'h03, 1, "R6");
    do_read(1, "R6");
    do_write(DEV, 8'h04, 3, "R9");
    pwr_ok = 1'b1;
    do_write(DEV, 8'h04, 3, "R7");
    do_write(DEV, 8'h01, 1, "R7");
    pwr_ok = 1'b0;
    do_write(DEV, 8'h05, 4, "R5");
    do_read(3, "R5");
    do_write(DEV, 8'h20, 2, "R5");
    do_read(2, "R8");
    do_write(DEV, 8'hFF, 1, "R5");
    do_write(7'h57, 8'h00, 1, "R3");
    do_write(DEV, 8'h02, 0, "R4");
    do_read(3, "R8");

    for (int t = 0; t < 30; t++) begin
      pwr_ok = ($urandom_range(0, 2) == 0);
      case ($urandom_range(0, 3))
        0, 1: do_write(DEV, 8'($urandom_range(0, 9)), $urandom_range(1, 4), "R4");
        2:    do_read($urandom_range(1, 4), "R8");
        default: do_write(DEV ^ 7'($urandom_range(1, 127)), 8'h00, 1, "R3");
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule